// File: doc/BRIEF.md
# Field-Gap Write Command Decoder

This block sits behind the gap detector of a passive transponder and turns a burst of carrier interruptions into one decoded write command. It runs on the field clock. A single-cycle, already synchronized gap pulse is its only data input. The first gap of a burst opens write mode. After that, the number of field clocks between each pair of gaps carries one bit. A long quiet period closes the burst, and the collected frame is then judged.

The frame is judged against the op-code, the number of bits received, and the two mode flags: password enable and answer-on-request. When password mode is on, the password field is compared with a stored 32-bit word. The decoder reports one of the following: a program command, a wake-up, a stop, a direct block read, or an error. For a program command it first waits a fixed number of field clocks. During that wait it watches the lock bit of the addressed block, which the memory returns for the presented address. If the block is unlocked, it raises a one-cycle program request. All results are held on the outputs until the consumer acknowledges them.

Top module: `gapwr_decoder`

## Requirements
- R1: A gap while idle (and with no result awaiting acknowledge) switches `wr_active` high from the next cycle. This start gap contributes no bit to the frame.
- R2: The interval is the number of clock cycles from one gap pulse to the next. An interval of 16..31 is a '0', and an interval of 48..64 is a '1'. Any other interval of 64 or less is an interval error that fails the frame.
- R3: When 65 cycles pass after the last gap with no further gap, write mode ends. The frame is judged at that edge, and for non-program outcomes `cmd_valid` is high from the next cycle.
- R4: The first two received bits form the op-code, with the first bit as its MSB. 10 is the standard code and 11 is stop. Any other code, or a frame shorter than two bits, is an error.
- R5: With password mode off and op-code 10, a 38-bit frame is a program command and a 6-bit frame is a direct read (`cmd_type` 1 and 4). The fields after the op-code come in this order: the lock bit, then for a program command the 32 data bits MSB first, then the 3 address bits MSB first.
- R6: With password mode on and op-code 10, the 32 bits after the op-code are compared with `stored_pwd`, the first received bit against bit 31. A 70-bit frame is a program command. A 34-bit frame is a wake-up (`cmd_type` 2) when answer-on-request is set. Any mismatch is an error.
- R7: Op-code 11 is a stop (`cmd_type` 3) only when the frame holds exactly 2 bits. With any extra bit the frame is an error.
- R8: A failed frame sets `cmd_valid` and `cmd_err` with `cmd_type` 0, and never pulses `prog_req`.
- R9: For an accepted program command, `prog_req` and `cmd_valid` rise 32 cycles after the frame is judged. `prog_req` lasts exactly one cycle.
- R10: If `tgt_locked` is high in any cycle of that 32-cycle wait, programming is aborted. In that case `cmd_valid` and `cmd_err` rise the next cycle with `cmd_type` 1, and `prog_req` stays low.
- R11: A posted result holds until `cmd_ack`. The acknowledge clears `cmd_valid`, `cmd_err` and `cmd_type`. Gaps that arrive while a result is held are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Field clock |
| rst_n | input | 1 | Active-low reset |
| gap_pulse | input | 1 | One-cycle synchronized gap detect |
| pwd_en | input | 1 | Password mode flag |
| aor_en | input | 1 | Answer-on-request mode flag |
| stored_pwd | input | 32 | Stored password word |
| tgt_locked | input | 1 | Lock bit of the block at `cmd_addr` |
| cmd_ack | input | 1 | Acknowledge of the held result |
| wr_active | output | 1 | Write mode in progress |
| cmd_valid | output | 1 | Result posted and held |
| cmd_type | output | 3 | 0 none, 1 program, 2 wake-up, 3 stop, 4 direct read |
| cmd_err | output | 1 | Frame or lock failure |
| cmd_lock | output | 1 | Received lock bit |
| cmd_addr | output | 3 | Received block address |
| cmd_data | output | 32 | Received data word |
| prog_req | output | 1 | One-cycle program request |

## Verification
The bench builds the decoder with its default parameters: 32-bit data and password, a 3-bit address, bit windows of 16..31 and 48..64, a quiet limit of 64 and a 32-cycle program wait. With these values every legal frame length can be reached, including the 70-bit password write. The bench hits each window edge exactly and one cycle outside it, and it can hold the lock input during the whole wait. A behavioural model in the bench tracks write mode and the program pulse on every cycle, and it judges each frame from the interval list alone.

// File: rtl/gapwr_pkg.sv
package gapwr_pkg;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_PROG = 3'd1,
    CMD_WAKE = 3'd2,
    CMD_STOP = 3'd3,
    CMD_READ = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_WAIT  = 2'd2
  } st_e;

  // Interval classification: {ok, value}
  function automatic logic [1:0] classify(input int iv, input int z_lo,
                                          input int z_hi, input int o_lo,
                                          input int top);
    if (iv >= z_lo && iv <= z_hi) return 2'b10;
    if (iv >= o_lo && iv <= top)  return 2'b11;
    return 2'b00;
  endfunction

endpackage

// File: rtl/gapwr_interval.sv
module gapwr_interval
  import gapwr_pkg::*;
#(
  parameter int T0_MIN = 16,
  parameter int T0_MAX = 31,
  parameter int T1_MIN = 48,
  parameter int QUIET  = 64,
  parameter int CNT_W  = $clog2(QUIET + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  input  logic gap,
  output logic bit_stb,
  output logic bit_ok,
  output logic bit_val,
  output logic quiet_end
);

  localparam logic [CNT_W-1:0] END_V = CNT_W'(QUIET + 1);

  logic [CNT_W-1:0] cnt;
  logic [1:0]       cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || (active && gap && cnt != END_V)) begin
      cnt <= CNT_W'(1);
    end else if (active && cnt != END_V) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign quiet_end = active && (cnt == END_V);
  assign bit_stb   = active && gap && !quiet_end;
  assign cls       = classify(int'(cnt), T0_MIN, T0_MAX, T1_MIN, QUIET);
  assign bit_ok    = cls[1];
  assign bit_val   = cls[0];

  // R3
  quiet_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_end |=> !quiet_end);

endmodule

// File: rtl/gapwr_collect.sv
module gapwr_collect #(
  parameter int PWD_W = 32,
  parameter int PAY_W = 36,
  parameter int NB_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bit_stb,
  input  logic             bit_ok,
  input  logic             bit_val,
  input  logic             pwd_en,
  input  logic [PWD_W-1:0] pwd_ref,
  output logic [NB_W-1:0]  nbits,
  output logic [1:0]       opcode,
  output logic             pwd_bad,
  output logic             iv_bad,
  output logic [PAY_W-1:0] payload
);

  logic pw_slot, pay_slot, ref_bit;

  assign pw_slot  = pwd_en && int'(nbits) >= 2 && int'(nbits) < PWD_W + 2;
  assign pay_slot = pwd_en ? (int'(nbits) >= PWD_W + 2) : (int'(nbits) >= 2);

  // First password bit (index 2) meets the stored MSB.
  always_comb begin
    ref_bit = 1'b0;
    for (int i = 0; i < PWD_W; i++) begin
      if (int'(nbits) == PWD_W + 1 - i) ref_bit = pwd_ref[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbits   <= '0;
      opcode  <= '0;
      pwd_bad <= 1'b0;
      iv_bad  <= 1'b0;
      payload <= '0;
    end else if (clear) begin
      nbits   <= '0;
      opcode  <= '0;
      pwd_bad <= 1'b0;
      iv_bad  <= 1'b0;
      payload <= '0;
    end else if (bit_stb) begin
      if (!bit_ok) begin
        iv_bad <= 1'b1;
      end else begin
        if (nbits != '1) nbits <= nbits + NB_W'(1);
        if (nbits == NB_W'(0)) opcode[1] <= bit_val;
        if (nbits == NB_W'(1)) opcode[0] <= bit_val;
        if (pw_slot && bit_val != ref_bit) pwd_bad <= 1'b1;
        if (pay_slot) payload <= {payload[PAY_W-2:0], bit_val};
      end
    end
  end

  // R1
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (nbits == '0 && !iv_bad && !pwd_bad));

  // R2
  bad_interval_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iv_bad && !clear) |=> iv_bad);

endmodule

// File: rtl/gapwr_delay.sv
module gapwr_delay #(
  parameter int DELAY = 32,
  parameter int DW    = $clog2(DELAY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic locked,
  output logic fire,
  output logic abort
);

  logic [DW-1:0] dly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           dly <= '0;
    else if (start)       dly <= '0;
    else if (run && !fire) dly <= dly + DW'(1);
  end

  assign abort = run && locked;
  assign fire  = run && !locked && (dly == DW'(DELAY - 1));

  // R10
  fire_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && abort));

endmodule

// File: rtl/gapwr_decoder.sv
module gapwr_decoder
  import gapwr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3,
  parameter int T0_MIN     = 16,
  parameter int T0_MAX     = 31,
  parameter int T1_MIN     = 48,
  parameter int QUIET      = 64,
  parameter int PROG_DELAY = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gap_pulse,
  input  logic              pwd_en,
  input  logic              aor_en,
  input  logic [DATA_W-1:0] stored_pwd,
  input  logic              tgt_locked,
  input  logic              cmd_ack,
  output logic              wr_active,
  output logic              cmd_valid,
  output logic [2:0]        cmd_type,
  output logic              cmd_err,
  output logic              cmd_lock,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              prog_req
);

  localparam int LEN_STOP = 2;
  localparam int LEN_READ = 3 + ADDR_W;
  localparam int LEN_STD  = 3 + DATA_W + ADDR_W;
  localparam int LEN_PWD  = LEN_STD + DATA_W;
  localparam int LEN_WAKE = 2 + DATA_W;
  localparam int PAY_W    = 1 + DATA_W + ADDR_W;
  localparam int NB_W     = $clog2(LEN_PWD + 2);
  localparam int CNT_W    = $clog2(QUIET + 2);

  st_e  state;
  cmd_e type_q, v_type;
  logic v_err;

  logic             start_ok, active;
  logic             bit_stb, bit_ok, bit_val, quiet_end;
  logic [NB_W-1:0]  nbits;
  logic [1:0]       opcode;
  logic             pwd_bad, iv_bad;
  logic [PAY_W-1:0] payload;
  logic             dly_start, fire, abort;

  assign active    = (state == ST_WRITE);
  assign start_ok  = (state == ST_IDLE) && gap_pulse && !cmd_valid;
  assign wr_active = active;
  assign cmd_type  = type_q;

  gapwr_interval #(
    .T0_MIN(T0_MIN), .T0_MAX(T0_MAX), .T1_MIN(T1_MIN),
    .QUIET(QUIET), .CNT_W(CNT_W)
  ) u_interval (
    .clk(clk), .rst_n(rst_n), .restart(start_ok), .active(active),
    .gap(gap_pulse), .bit_stb(bit_stb), .bit_ok(bit_ok),
    .bit_val(bit_val), .quiet_end(quiet_end)
  );

  gapwr_collect #(
    .PWD_W(DATA_W), .PAY_W(PAY_W), .NB_W(NB_W)
  ) u_collect (
    .clk(clk), .rst_n(rst_n), .clear(start_ok), .bit_stb(bit_stb),
    .bit_ok(bit_ok), .bit_val(bit_val), .pwd_en(pwd_en),
    .pwd_ref(stored_pwd), .nbits(nbits), .opcode(opcode),
    .pwd_bad(pwd_bad), .iv_bad(iv_bad), .payload(payload)
  );

  gapwr_delay #(.DELAY(PROG_DELAY)) u_delay (
    .clk(clk), .rst_n(rst_n), .start(dly_start),
    .run(state == ST_WAIT), .locked(tgt_locked),
    .fire(fire), .abort(abort)
  );

  // Frame verdict
  always_comb begin
    v_type = CMD_NONE;
    v_err  = 1'b1;
    if (!iv_bad && int'(nbits) >= 2) begin
      if (opcode == 2'b11) begin
        if (int'(nbits) == LEN_STOP) begin
          v_type = CMD_STOP; v_err = 1'b0;
        end
      end else if (opcode == 2'b10) begin
        if (!pwd_en) begin
          if (int'(nbits) == LEN_STD) begin
            v_type = CMD_PROG; v_err = 1'b0;
          end else if (int'(nbits) == LEN_READ) begin
            v_type = CMD_READ; v_err = 1'b0;
          end
        end else if (!pwd_bad) begin
          if (int'(nbits) == LEN_PWD) begin
            v_type = CMD_PROG; v_err = 1'b0;
          end else if (int'(nbits) == LEN_WAKE && aor_en) begin
            v_type = CMD_WAKE; v_err = 1'b0;
          end
        end
      end
    end
  end

  assign dly_start = active && quiet_end && !v_err && v_type == CMD_PROG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      type_q    <= CMD_NONE;
      cmd_valid <= 1'b0;
      cmd_err   <= 1'b0;
      cmd_lock  <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      prog_req  <= 1'b0;
    end else begin
      prog_req <= 1'b0;
      if (cmd_ack && cmd_valid) begin
        cmd_valid <= 1'b0;
        cmd_err   <= 1'b0;
        type_q    <= CMD_NONE;
      end
      unique case (state)
        ST_IDLE: if (start_ok) state <= ST_WRITE;
        ST_WRITE: if (quiet_end) begin
          if (v_err) begin
            cmd_valid <= 1'b1;
            cmd_err   <= 1'b1;
            type_q    <= CMD_NONE;
            state     <= ST_IDLE;
          end else begin
            type_q   <= v_type;
            cmd_addr <= payload[ADDR_W-1:0];
            if (v_type == CMD_READ) begin
              cmd_lock <= payload[ADDR_W];
            end else if (v_type == CMD_PROG) begin
              cmd_lock <= payload[PAY_W-1];
              cmd_data <= payload[ADDR_W +: DATA_W];
            end
            if (v_type == CMD_PROG) begin
              state <= ST_WAIT;
            end else begin
              cmd_valid <= 1'b1;
              state     <= ST_IDLE;
            end
          end
        end
        ST_WAIT: begin
          if (abort) begin
            cmd_valid <= 1'b1;
            cmd_err   <= 1'b1;
            state     <= ST_IDLE;
          end else if (fire) begin
            cmd_valid <= 1'b1;
            prog_req  <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  prog_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);

  // R10
  lock_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> !$past(tgt_locked));

  // R11
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_type) && $stable(cmd_err)));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && cmd_valid && gap_pulse) |=> !wr_active);

  // R8
  err_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_err) |-> (cmd_type == 3'd0 || cmd_type == 3'd1));

endmodule

// File: tb/gapwr_decoder_bench.sv
`timescale 1ns/1ps
module gapwr_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gap = 1'b0;
  logic        pe = 1'b0, ae = 1'b0, locked = 1'b0, ack = 1'b0;
  logic [31:0] pw = 32'h0A5C_3E91;
  logic        wr_active, cmd_valid, cmd_err, cmd_lock, prog_req;
  logic [2:0]  cmd_type, cmd_addr;
  logic [31:0] cmd_data;

  int vectors = 0;
  int miscompares = 0;
  bit mon_en = 1'b0;
  bit exp_wr = 1'b0;
  bit exp_pr = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gapwr_decoder u_gapwr_decoder (
    .clk(clk), .rst_n(rst_n), .gap_pulse(gap), .pwd_en(pe), .aor_en(ae),
    .stored_pwd(pw), .tgt_locked(locked), .cmd_ack(ack),
    .wr_active(wr_active), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_err(cmd_err), .cmd_lock(cmd_lock), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .prog_req(prog_req)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle model comparison of write mode and program pulse
  always @(negedge clk) begin
    #1;
    if (mon_en) begin
      chk("R1/R3 wr_active per cycle", wr_active, exp_wr);
      chk("R9 prog_req per cycle", prog_req, exp_pr);
    end
  end

  function automatic void add_bits(ref int q[$], input logic [63:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) q.push_back(v[i] ? 56 : 24);
  endfunction

  // Reference judgement of a frame from its bits
  function automatic void ref_eval(input bit b[$], input bit ivf,
                                   output int typ, output bit err, output bit lk,
                                   output logic [31:0] dat, output int adr);
    int n = b.size();
    int base;
    typ = 0; err = 1'b1; lk = 1'b0; dat = '0; adr = 0;
    if (ivf || n < 2) return;
    if (b[0] && b[1]) begin
      if (n == 2) begin typ = 3; err = 1'b0; end
      return;
    end
    if (!(b[0] && !b[1])) return;
    if (pe) begin
      if (!(n == 70 || (n == 34 && ae))) return;
      for (int i = 0; i < 32; i++) if (b[2+i] != pw[31-i]) return;
      if (n == 34) begin typ = 2; err = 1'b0; return; end
      base = 34;
    end else begin
      if (!(n == 38 || n == 6)) return;
      base = 2;
    end
    lk = b[base];
    if (n == 6) begin
      adr = b[3]*4 + b[4]*2 + b[5];
      typ = 4; err = 1'b0; return;
    end
    for (int i = 0; i < 32; i++) dat[31-i] = b[base+1+i];
    adr = b[base+33]*4 + b[base+34]*2 + b[base+35];
    typ = 1; err = 1'b0;
  endfunction

  task automatic pulse_after(input int n);
    repeat (n - 1) @(negedge clk);
    gap = 1'b1;
    @(negedge clk);
    gap = 1'b0;
  endtask

  task automatic do_frame(input string nm, input int ivs[$], input bit do_ack);
    bit b[$];
    bit ivf = 1'b0;
    int typ, adr;
    bit err, lk;
    logic [31:0] dat;
    foreach (ivs[i]) begin
      if (ivs[i] >= 16 && ivs[i] <= 31) b.push_back(1'b0);
      else if (ivs[i] >= 48 && ivs[i] <= 64) b.push_back(1'b1);
      else ivf = 1'b1;
    end
    ref_eval(b, ivf, typ, err, lk, dat, adr);
    @(negedge clk); gap = 1'b1;
    @(negedge clk); gap = 1'b0; exp_wr = 1'b1;
    foreach (ivs[i]) pulse_after(ivs[i]);
    repeat (64) @(negedge clk);
    #2;
    chk({nm, " R3 still writing at 64"}, {cmd_valid, wr_active}, 2'b01);
    @(negedge clk); exp_wr = 1'b0; #2;
    if (err || typ != 1) begin
      chk({nm, " R3/R8 valid"}, cmd_valid, 1'b1);
      chk({nm, " R4-R8 type"}, cmd_type, err ? 3'd0 : 3'(typ));
      chk({nm, " R8 err"}, cmd_err, err);
      if (!err && typ == 4) chk({nm, " R5 read fields"}, {cmd_lock, cmd_addr}, {lk, 3'(adr)});
    end else begin
      chk({nm, " R9 no valid yet"}, cmd_valid, 1'b0);
      if (locked) begin
        @(negedge clk); #2;
        chk({nm, " R10 abort"}, {cmd_valid, cmd_err, cmd_type}, {2'b11, 3'd1});
      end else begin
        repeat (31) @(negedge clk);
        #2;
        chk({nm, " R9 wait"}, cmd_valid, 1'b0);
        exp_pr = 1'b1;
        @(negedge clk); #2;
        chk({nm, " R9 result"}, {cmd_valid, cmd_err, cmd_type}, {2'b10, 3'd1});
        chk({nm, " R5 fields"}, {cmd_lock, cmd_addr, cmd_data}, {lk, 3'(adr), dat});
        @(negedge clk); exp_pr = 1'b0;
      end
    end
    if (do_ack) begin
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0; #2;
      chk({nm, " R11 ack clears"}, {cmd_valid, cmd_err, cmd_type}, 5'd0);
    end
  endtask

  initial begin
    int q[$];
    repeat (3) @(negedge clk);
    #2;
    chk("R8 reset outputs", {cmd_valid, cmd_err, prog_req, wr_active, cmd_type}, 7'd0);
    rst_n = 1'b1;
    mon_en = 1'b1;

    // R5 standard write
    q = {}; add_bits(q, 2'b10, 2); add_bits(q, 0, 1); add_bits(q, 32'hC3A5_1E07, 32); add_bits(q, 5, 3);
    do_frame("std", q, 1'b1);
    // R5 direct read using window edges (R2): 56,16,31,24,64,48 -> 1 0 0 0 1 1
    q = {56, 16, 31, 24, 64, 48};
    do_frame("read edges", q, 1'b1);
    // R7 stop with 48 and 64 edges
    q = {48, 64};
    do_frame("stop", q, 1'b1);
    // R7 stop with an extra bit
    q = {56, 56, 24};
    do_frame("stop+1", q, 1'b1);
    // R4 bad opcode
    q = {24, 56};
    do_frame("op01", q, 1'b1);
    // R2 out-of-window intervals
    q = {56, 15}; do_frame("iv15", q, 1'b1);
    q = {56, 32}; do_frame("iv32", q, 1'b1);
    q = {56, 47}; do_frame("iv47", q, 1'b1);
    // R5 wrong length 37
    q = {}; add_bits(q, 2'b10, 2); add_bits(q, 64'h1_2345_6789, 35);
    do_frame("len37", q, 1'b1);
    // R6 password write
    pe = 1'b1;
    q = {}; add_bits(q, 2'b10, 2); add_bits(q, pw, 32); add_bits(q, 1, 1);
    add_bits(q, 32'h5A5A_0FF0, 32); add_bits(q, 6, 3);
    do_frame("pwd write", q, 1'b1);
    q = {}; add_bits(q, 2'b10, 2); add_bits(q, pw ^ 32'h0000_0100, 32); add_bits(q, 1, 1);
    add_bits(q, 32'h5A5A_0FF0, 32); add_bits(q, 6, 3);
    do_frame("pwd mismatch", q, 1'b1);
    // R6 wake-up
    ae = 1'b1;
    q = {}; add_bits(q, 2'b10, 2); add_bits(q, pw, 32);
    do_frame("wake", q, 1'b1);
    q = {}; add_bits(q, 2'b10, 2); add_bits(q, pw ^ 32'h8000_0000, 32);
    do_frame("wake bad pwd", q, 1'b1);
    ae = 1'b0;
    q = {}; add_bits(q, 2'b10, 2); add_bits(q, pw, 32);
    do_frame("wake no aor", q, 1'b1);
    // R6 direct read not legal in password mode
    q = {56, 24, 24, 56, 24, 56};
    do_frame("read in pwd", q, 1'b1);
    pe = 1'b0;
    // R10 locked target
    locked = 1'b1;
    q = {}; add_bits(q, 2'b10, 2); add_bits(q, 1, 1); add_bits(q, 32'hFFFF_0000, 32); add_bits(q, 2, 3);
    do_frame("locked", q, 1'b1);
    locked = 1'b0;
    // R11 gaps ignored while a result is held
    q = {56, 56};
    do_frame("stop held", q, 1'b0);
    @(negedge clk); gap = 1'b1;
    @(negedge clk); gap = 1'b0;
    repeat (70) @(negedge clk);
    #2;
    chk("R11 held result unchanged", {cmd_valid, cmd_err, cmd_type}, {2'b10, 3'd3});
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0; #2;
    chk("R11 ack clears", cmd_valid, 1'b0);
    // R1 after ack a new frame is accepted
    q = {56, 56};
    do_frame("stop again", q, 1'b1);

    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule